// File: doc/BRIEF.md
# Direct-Mapped Branch Target Predictor

This block predicts control-transfer direction for a two-stage pipeline made of a fetch stage and an execute stage. In fetch it takes the sequential address of the instruction being fetched (its PC plus 4) and looks that address up in a small direct-mapped table. A hit means the branch is predicted taken, and the stored target becomes the next PC. A miss means fall-through, and the next PC is PC plus 4.

The prediction bit moves with the instruction into execute. There the resolved outcome from the datapath is compared with it. If a taken branch was predicted not-taken, the block kills the fetched instruction, redirects to the real target and writes the pair (PC plus 4, target) into the table. If a not-taken branch was predicted taken, the block kills and redirects to PC plus 4 and leaves the table as it is. A taken register-indirect jump is never predicted. It always kills the fetched instruction and redirects to its target.

Top module: `btb_predictor`

## Requirements
- R1: After a synchronous active-low reset, every entry is invalid and the pipelined prediction bit is 0. No lookup hits until an entry has been written, and no execute-stage instruction is treated as predicted taken.
- R2: The entry index is bits [IDX_W+1:2] of the lookup address, where IDX_W = log2(ENTRIES). A hit needs the entry to be valid and its stored address to equal the whole lookup address. An address that shares an index with a stored address but differs in other bits misses.
- R3: On a hit, `f_pred_taken` is 1, `f_pred_target` is the stored target and `f_next_pc` is that target. On a miss, `f_pred_taken` is 0 and `f_next_pc` equals `f_pc_plus4`, unless a redirect is active.
- R4: A valid execute-stage branch that resolves taken with a prediction bit of 0 raises `x_mispredict` and sets `x_redirect_pc` to `x_target`. The table is written at the end of that cycle, so a lookup of the same address in the next cycle hits with that target.
- R5: A valid branch that resolves not-taken with a prediction bit of 1 raises `x_mispredict`, sets `x_redirect_pc` to `x_pc_plus4` and does not change the table.
- R6: A correctly predicted branch, whether taken with a prediction of 1 or not-taken with a prediction of 0, raises no mispredict and does not change the table.
- R7: A valid taken register-indirect jump always raises `x_mispredict` with `x_redirect_pc` equal to `x_target`, and it never writes the table.
- R8: While `x_mispredict` is 1, `f_next_pc` equals `x_redirect_pc`, even if the fetch lookup hits in the same cycle.
- R9: The execute-stage prediction bit is the `f_pred_taken` value of the previous cycle. It is forced to 0 when that previous cycle raised a mispredict, because the fetched instruction was killed. With `x_valid` at 0, no mispredict is raised.
- R10: Writing an index that holds a different address replaces the old entry. The old address then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| f_pc_plus4 | input | XLEN | Sequential address of the instruction in fetch |
| f_pred_taken | output | 1 | Fetch lookup hit (predict taken) |
| f_pred_target | output | XLEN | Stored target on a hit, 0 otherwise |
| f_next_pc | output | XLEN | Selected next PC |
| x_valid | input | 1 | Execute stage holds a live instruction |
| x_is_branch | input | 1 | Execute instruction is a conditional branch or direct jump |
| x_is_jalr | input | 1 | Execute instruction is a register-indirect jump |
| x_taken | input | 1 | Resolved outcome of the execute instruction |
| x_pc_plus4 | input | XLEN | Sequential address of the execute instruction |
| x_target | input | XLEN | Resolved target of the execute instruction |
| x_mispredict | output | 1 | Kill the fetched instruction and redirect |
| x_redirect_pc | output | XLEN | Correct next PC when mispredicting |

## Verification
The bench builds the block with XLEN = 32 and ENTRIES = 4. With only two index bits, [3:2], it is easy to pick addresses that collide, such as 0x104 and 0x184, or 0x108 and 0x208. This reaches the aliasing miss, the overwrite of an entry and a lookup of an entry that was just written. Because the table is so small, the bench can also set up a mispredict and a fetch hit in the same cycle, and then check the killed prediction bit in the following cycle.

// File: rtl/btb_pkg.sv
// Shared types for the branch target predictor.
package btb_pkg;
    // Classification of what the execute stage resolved.
    typedef enum logic [1:0] {
        RES_NONE        = 2'd0,  // correct or not a control transfer
        RES_LATE_TAKEN  = 2'd1,  // predicted fall-through, went taken
        RES_FALSE_TAKEN = 2'd2,  // predicted taken, fell through
        RES_INDIRECT    = 2'd3   // taken register-indirect jump
    } res_kind_e;
endpackage

// File: rtl/btb_table.sv
// Direct-mapped storage of (sequential address, target) pairs with valid bits.
// Lookup is combinational. Writes land at the clock edge, so a lookup in the
// cycle of a write sees the old contents. Assumes ENTRIES is a power of two, at least 2.
module btb_table #(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned ENTRIES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] rd_addr,
    output logic            rd_hit,
    output logic [XLEN-1:0] rd_target,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_addr,
    input  logic [XLEN-1:0] wr_target
);
    localparam int unsigned IDX_W   = $clog2(ENTRIES);
    localparam int unsigned IDX_LSB = 2;

    logic [IDX_W-1:0]   rd_idx;
    logic [IDX_W-1:0]   wr_idx;
    logic [ENTRIES-1:0] ent_match;
    logic [XLEN-1:0]    ent_masked [ENTRIES];

    assign rd_idx = rd_addr[IDX_LSB +: IDX_W];
    assign wr_idx = wr_addr[IDX_LSB +: IDX_W];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic            ent_valid;
        logic [XLEN-1:0] ent_tag;
        logic [XLEN-1:0] ent_tgt;
        logic            sel_wr;

        assign sel_wr = wr_en && (wr_idx == IDX_W'(e));

        // Valid bit: cleared on reset, set by the first write, never cleared again.
        always_ff @(posedge clk) begin
            if (!rst_n)      ent_valid <= 1'b0;
            else if (sel_wr) ent_valid <= 1'b1;
        end

        // Address and target payload; no reset needed behind the valid bit.
        always_ff @(posedge clk) begin
            if (sel_wr) begin
                ent_tag <= wr_addr;
                ent_tgt <= wr_target;
            end
        end

        assign ent_match[e]  = ent_valid && (rd_idx == IDX_W'(e)) && (ent_tag == rd_addr);
        assign ent_masked[e] = ent_match[e] ? ent_tgt : '0;
    end

    // Reduce the one-hot match vector to a hit flag and target.
    always_comb begin
        rd_target = '0;
        for (int e = 0; e < ENTRIES; e++) rd_target = rd_target | ent_masked[e];
        rd_hit = |ent_match;
    end
endmodule

// File: rtl/btb_resolve.sv
// Execute-stage resolution. Compares the pipelined prediction with the real
// outcome, decides whether to kill and redirect, and whether to allocate.
// Assumes at most one of is_branch / is_jalr is set.
module btb_resolve
    import btb_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic            valid,
    input  logic            is_branch,
    input  logic            is_jalr,
    input  logic            taken,
    input  logic            pred_taken,
    input  logic [XLEN-1:0] pc_plus4,
    input  logic [XLEN-1:0] target,
    output res_kind_e       kind,
    output logic            mispredict,
    output logic [XLEN-1:0] redirect_pc,
    output logic            alloc
);
    // Classify the resolved instruction.
    always_comb begin
        kind = RES_NONE;
        if (valid) begin
            if (is_jalr && taken)                    kind = RES_INDIRECT;
            else if (is_branch && taken && !pred_taken) kind = RES_LATE_TAKEN;
            else if (is_branch && !taken && pred_taken) kind = RES_FALSE_TAKEN;
        end
    end

    // Derive kill, redirect address and allocation from the class.
    always_comb begin
        mispredict  = (kind != RES_NONE);
        alloc       = (kind == RES_LATE_TAKEN);
        redirect_pc = (kind == RES_FALSE_TAKEN) ? pc_plus4 : target;
    end
endmodule

// File: rtl/btb_nextpc.sv
// Next-PC selection. An execute redirect wins over a fetch prediction, which
// wins over the sequential address.
module btb_nextpc #(
    parameter int unsigned XLEN = 32
) (
    input  logic            redirect,
    input  logic [XLEN-1:0] redirect_pc,
    input  logic            pred_hit,
    input  logic [XLEN-1:0] pred_target,
    input  logic [XLEN-1:0] seq_pc,
    output logic [XLEN-1:0] next_pc
);
    // Priority mux of the three sources.
    always_comb begin
        if (redirect)      next_pc = redirect_pc;
        else if (pred_hit) next_pc = pred_target;
        else               next_pc = seq_pc;
    end
endmodule

// File: rtl/btb_predictor.sv
// Top of the branch target predictor: table lookup in fetch, a one-bit
// prediction pipeline register, resolution in execute and next-PC selection.
// Assumes the datapath presents, in execute, the instruction that was fetched
// in the previous cycle.
module btb_predictor
    import btb_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned ENTRIES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] f_pc_plus4,
    output logic            f_pred_taken,
    output logic [XLEN-1:0] f_pred_target,
    output logic [XLEN-1:0] f_next_pc,
    input  logic            x_valid,
    input  logic            x_is_branch,
    input  logic            x_is_jalr,
    input  logic            x_taken,
    input  logic [XLEN-1:0] x_pc_plus4,
    input  logic [XLEN-1:0] x_target,
    output logic            x_mispredict,
    output logic [XLEN-1:0] x_redirect_pc
);
    logic      x_pred_q;
    logic      alloc;
    res_kind_e kind;

    btb_table #(.XLEN(XLEN), .ENTRIES(ENTRIES)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (f_pc_plus4),
        .rd_hit   (f_pred_taken),
        .rd_target(f_pred_target),
        .wr_en    (alloc),
        .wr_addr  (x_pc_plus4),
        .wr_target(x_target)
    );

    // Carry the fetch prediction to execute; a killed fetch carries 0.
    always_ff @(posedge clk) begin
        if (!rst_n) x_pred_q <= 1'b0;
        else        x_pred_q <= f_pred_taken && !x_mispredict;
    end

    btb_resolve #(.XLEN(XLEN)) u_resolve (
        .valid      (x_valid),
        .is_branch  (x_is_branch),
        .is_jalr    (x_is_jalr),
        .taken      (x_taken),
        .pred_taken (x_pred_q),
        .pc_plus4   (x_pc_plus4),
        .target     (x_target),
        .kind       (kind),
        .mispredict (x_mispredict),
        .redirect_pc(x_redirect_pc),
        .alloc      (alloc)
    );

    btb_nextpc #(.XLEN(XLEN)) u_nextpc (
        .redirect   (x_mispredict),
        .redirect_pc(x_redirect_pc),
        .pred_hit   (f_pred_taken),
        .pred_target(f_pred_target),
        .seq_pc     (f_pc_plus4),
        .next_pc    (f_next_pc)
    );
endmodule

// File: rtl/btb_predictor_chk.sv
// Property checker for btb_predictor, attached with bind below.
module btb_predictor_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] f_pc_plus4,
    input logic            f_pred_taken,
    input logic [XLEN-1:0] f_pred_target,
    input logic [XLEN-1:0] f_next_pc,
    input logic            x_valid,
    input logic            x_is_branch,
    input logic            x_is_jalr,
    input logic            x_taken,
    input logic [XLEN-1:0] x_pc_plus4,
    input logic [XLEN-1:0] x_target,
    input logic            x_mispredict,
    input logic [XLEN-1:0] x_redirect_pc
);
    // R1: the first cycle after reset sees an empty table.
    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !f_pred_taken);

    // R3: no redirect and no hit selects the sequential address.
    a_r3_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (!x_mispredict && !f_pred_taken) |-> (f_next_pc == f_pc_plus4));

    // R4: an allocated pair is found by a lookup of the same address next cycle.
    a_r4_alloc_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (x_mispredict && x_valid && x_is_branch && x_taken) |=>
        ((f_pc_plus4 == $past(x_pc_plus4)) -> (f_pred_taken && f_pred_target == $past(x_target))));

    // R5: a false-taken mispredict goes back to the sequential address.
    a_r5_false_taken_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (x_mispredict && x_valid && x_is_branch && !x_taken) |-> (x_redirect_pc == x_pc_plus4));

    // R7: taken indirect jumps always redirect to their target.
    a_r7_indirect: assert property (@(posedge clk) disable iff (!rst_n)
        (x_valid && x_is_jalr && x_taken) |-> (x_mispredict && x_redirect_pc == x_target));

    // R8: a redirect overrides any fetch prediction.
    a_r8_redirect_wins: assert property (@(posedge clk) disable iff (!rst_n)
        x_mispredict |-> (f_next_pc == x_redirect_pc));

    // R9: no live instruction, no mispredict.
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !x_valid |-> !x_mispredict);
endmodule

bind btb_predictor btb_predictor_chk #(.XLEN(XLEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .f_pc_plus4   (f_pc_plus4),
    .f_pred_taken (f_pred_taken),
    .f_pred_target(f_pred_target),
    .f_next_pc    (f_next_pc),
    .x_valid      (x_valid),
    .x_is_branch  (x_is_branch),
    .x_is_jalr    (x_is_jalr),
    .x_taken      (x_taken),
    .x_pc_plus4   (x_pc_plus4),
    .x_target     (x_target),
    .x_mispredict (x_mispredict),
    .x_redirect_pc(x_redirect_pc)
);

// File: tb/sim_btb_predictor.sv
// Self-checking bench: a table of per-cycle vectors, then directed reset tests.
module sim_btb_predictor;
    localparam int unsigned XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [XLEN-1:0] f_pc_plus4 = '0;
    logic            f_pred_taken;
    logic [XLEN-1:0] f_pred_target;
    logic [XLEN-1:0] f_next_pc;
    logic            x_valid = 1'b0;
    logic            x_is_branch = 1'b0;
    logic            x_is_jalr = 1'b0;
    logic            x_taken = 1'b0;
    logic [XLEN-1:0] x_pc_plus4 = '0;
    logic [XLEN-1:0] x_target = '0;
    logic            x_mispredict;
    logic [XLEN-1:0] x_redirect_pc;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    btb_predictor #(.XLEN(XLEN), .ENTRIES(4)) u0 (.*);

    typedef struct packed {
        logic [31:0] fpc;
        logic        xv, xb, xj, xt;
        logic [31:0] xpc, xtgt;
        logic        e_pred;
        logic [31:0] e_next;
        logic        e_misp;
        logic [31:0] e_redir;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        // R1 R3: empty table misses
        '{32'h104, 1'b0,1'b0,1'b0,1'b0, 32'h0,   32'h0,   1'b0, 32'h104, 1'b0, 32'h0},
        // R4 R8: late-taken allocates 0x104->0x180 (index 1)
        '{32'h200, 1'b1,1'b1,1'b0,1'b1, 32'h104, 32'h180, 1'b0, 32'h180, 1'b1, 32'h180},
        // R4 R3: written entry hits next cycle
        '{32'h104, 1'b0,1'b0,1'b0,1'b0, 32'h0,   32'h0,   1'b1, 32'h180, 1'b0, 32'h0},
        // R2: 0x184 aliases index 1 and misses; R6 correct taken
        '{32'h184, 1'b1,1'b1,1'b0,1'b1, 32'h104, 32'h180, 1'b0, 32'h184, 1'b0, 32'h0},
        // R3 hit again
        '{32'h104, 1'b0,1'b0,1'b0,1'b0, 32'h0,   32'h0,   1'b1, 32'h180, 1'b0, 32'h0},
        // R5: false-taken redirects to pc+4
        '{32'h180, 1'b1,1'b1,1'b0,1'b0, 32'h104, 32'h180, 1'b0, 32'h104, 1'b1, 32'h104},
        // R5: table unchanged, still hits
        '{32'h104, 1'b0,1'b0,1'b0,1'b0, 32'h0,   32'h0,   1'b1, 32'h180, 1'b0, 32'h0},
        // R6: predicted taken, resolved taken
        '{32'h108, 1'b1,1'b1,1'b0,1'b1, 32'h104, 32'h180, 1'b0, 32'h108, 1'b0, 32'h0},
        // R8: fetch hit while execute allocates 0x108->0x300
        '{32'h104, 1'b1,1'b1,1'b0,1'b1, 32'h108, 32'h300, 1'b1, 32'h300, 1'b1, 32'h300},
        // R9: killed hit carries prediction 0, so taken mispredicts
        '{32'h108, 1'b1,1'b1,1'b0,1'b1, 32'h104, 32'h180, 1'b1, 32'h180, 1'b1, 32'h180},
        // R7: indirect jump redirects
        '{32'h500, 1'b1,1'b0,1'b1,1'b1, 32'h10C, 32'h700, 1'b0, 32'h700, 1'b1, 32'h700},
        // R7: indirect jump not written
        '{32'h10C, 1'b0,1'b0,1'b0,1'b0, 32'h0,   32'h0,   1'b0, 32'h10C, 1'b0, 32'h0},
        // R10: 0x208 overwrites index 2
        '{32'h600, 1'b1,1'b1,1'b0,1'b1, 32'h208, 32'h400, 1'b0, 32'h400, 1'b1, 32'h400},
        // R10: old address now misses
        '{32'h108, 1'b0,1'b0,1'b0,1'b0, 32'h0,   32'h0,   1'b0, 32'h108, 1'b0, 32'h0},
        // R10: new address hits
        '{32'h208, 1'b0,1'b0,1'b0,1'b0, 32'h0,   32'h0,   1'b1, 32'h400, 1'b0, 32'h0},
        // R9: invalid execute slot ignored
        '{32'h700, 1'b0,1'b1,1'b0,1'b1, 32'h208, 32'h999, 1'b0, 32'h700, 1'b0, 32'h0},
        // R6: predicted not-taken, resolved not-taken; R2 alias 0x704 misses
        '{32'h704, 1'b1,1'b1,1'b0,1'b0, 32'h700, 32'h800, 1'b0, 32'h704, 1'b0, 32'h0}
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic drive_x(input logic v, b, j, t, input logic [31:0] pc, tg);
        x_valid = v; x_is_branch = b; x_is_jalr = j; x_taken = t;
        x_pc_plus4 = pc; x_target = tg;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset pred", {31'b0, f_pred_taken}, 32'd0);
        chk("R1 reset misp", {31'b0, x_mispredict}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            f_pc_plus4 = VECS[i].fpc;
            drive_x(VECS[i].xv, VECS[i].xb, VECS[i].xj, VECS[i].xt, VECS[i].xpc, VECS[i].xtgt);
            #1;
            chk($sformatf("vec %0d pred", i), {31'b0, f_pred_taken}, {31'b0, VECS[i].e_pred});
            chk($sformatf("vec %0d next_pc", i), f_next_pc, VECS[i].e_next);
            chk($sformatf("vec %0d mispredict", i), {31'b0, x_mispredict}, {31'b0, VECS[i].e_misp});
            if (VECS[i].e_misp)
                chk($sformatf("vec %0d redirect", i), x_redirect_pc, VECS[i].e_redir);
        end

        // R1: reset mid-run with a hitting lookup in flight clears table and prediction bit.
        @(negedge clk);
        f_pc_plus4 = 32'h208;
        drive_x(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        f_pc_plus4 = 32'h104;
        drive_x(1'b1, 1'b1, 1'b0, 1'b0, 32'h208, 32'h400);
        #1;
        chk("R1 entry 0x104 cleared", {31'b0, f_pred_taken}, 32'd0);
        chk("R1 pred bit cleared", {31'b0, x_mispredict}, 32'd0);
        @(negedge clk);
        f_pc_plus4 = 32'h208;
        drive_x(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
        #1;
        chk("R1 entry 0x208 cleared", f_next_pc, 32'h208);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule